// File: doc/BRIEF.md
# Serial Payload Sender with Overhead Holdoff

This block sits on the terminal side of a DS3 transmit framer and feeds it one payload bit per clock. It has no clock of its own: every register runs on the bit clock that the framer drives, and the serial output is updated on that clock's rising edge. The framer paces it with two single-clock pulses. A frame strobe marks the framer's last bit of a frame, and the sender answers by presenting the first payload bit of the next frame on the very next edge. An overhead warning announces that the framer is about to take an overhead bit, and the sender answers by leaving a one-clock gap, so that no payload bit falls into an overhead slot.

Payload arrives as parallel words through a valid/ready handshake and is shifted out MSB first. A word is taken only when a payload slot needs a bit and the shift register is empty. If no word is ready at that point, a fill bit goes out in the payload slot and a sticky underrun flag is raised. Before the first frame strobe after reset, and once a frame has received its full count of payload bits, the sender idles on fill bits and takes nothing.

Top module: `ser_src_tx`

## Requirements
- R1: While reset is asserted and right after it, `ser_o` is 1, `underrun_o` is 0 and `word_ready_o` is 0 whenever the frame strobe is low.
- R2: Until the first frame strobe is sampled after reset, every edge loads a fill bit of 1 into `ser_o` (0 on an overhead gap), and `word_ready_o` stays low.
- R3: On the edge where the frame strobe is sampled high and the overhead warning is low, `ser_o` takes the first payload bit of the new frame.
- R4: Words are sent MSB first and in the order they were accepted. Each accepted word fills `WORD_W` consecutive payload slots, and a word left unfinished at a frame boundary continues in the next frame.
- R5: On an edge where the overhead warning is sampled high, `ser_o` becomes 0, nothing is consumed, and the pending payload bit appears on the next payload slot, one clock later.
- R6: `word_ready_o` is high exactly in a payload slot where the shift register is empty. A word is accepted when `word_valid_i` and `word_ready_o` are both high.
- R7: A payload slot that needs a word while `word_valid_i` is low sends a 1 and sets `underrun_o`, which stays set until reset.
- R8: A frame carries at most `PAY_BITS` payload slots (default 4704). After that, each edge loads a 1 (0 on an overhead gap) and `word_ready_o` stays low until the next frame strobe.
- R9: A frame strobe that arrives before the payload count is reached starts a new frame and resets the count to zero.
- R10: If the frame strobe and the overhead warning are sampled together, that edge is a gap (0, no consumption) and the new frame's payload count starts at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock driven by the framer |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_strobe_i | input | 1 | One-clock pulse marking the framer's last bit of a frame |
| oh_warn_i | input | 1 | One-clock pulse warning that the next edge is an overhead slot |
| word_valid_i | input | 1 | Upstream word is valid |
| word_data_i | input | WORD_W | Upstream payload word, MSB sent first |
| word_ready_o | output | 1 | Word is accepted on this edge if valid |
| ser_o | output | 1 | Serial payload bit toward the framer |
| underrun_o | output | 1 | Sticky flag: a payload slot found no word |

## Verification
The bench places overhead warnings at random points. It also tests the warning and the frame strobe arriving on the same edge: a design that let the strobe win would send a payload bit into an overhead slot and shift the whole frame by one. Frames are strobed late enough that the payload limit is reached, so a design that kept popping past the limit would drain words the framer never wants. One frame is cut short by an early strobe to catch a count that fails to restart. Gaps in upstream validity catch fill bits that are not counted as payload slots and an underrun flag that clears itself.

// File: rtl/ser_src_pkg.sv
package ser_src_pkg;
    // Kind of slot the coming clock edge fills.
    typedef enum logic [1:0] {
        SLOT_IDLE = 2'd0,
        SLOT_GAP  = 2'd1,
        SLOT_PAY  = 2'd2
    } slot_e;
endpackage

// File: rtl/ser_src_slot_ctrl.sv
module ser_src_slot_ctrl
    import ser_src_pkg::*;
#(
    parameter int PAY_BITS = 4704
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  frame_strobe_i,
    input  logic  oh_warn_i,
    output slot_e slot_o
);
    localparam int CW = $clog2(PAY_BITS + 1);

    typedef struct packed {
        logic          in_frame;
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    slot_e slot;

    always_comb begin
        logic          active;
        logic          room;
        logic [CW-1:0] base;
        active = frame_strobe_i | st_q.in_frame;
        room   = frame_strobe_i | (st_q.cnt < CW'(PAY_BITS));
        base   = frame_strobe_i ? '0 : st_q.cnt;

        if (oh_warn_i)            slot = SLOT_GAP;
        else if (active && room)  slot = SLOT_PAY;
        else                      slot = SLOT_IDLE;

        st_d          = st_q;
        st_d.in_frame = active;
        st_d.cnt      = (slot == SLOT_PAY) ? base + CW'(1) : base;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign slot_o = slot;
endmodule

// File: rtl/ser_src_shifter.sv
module ser_src_shifter
    import ser_src_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  slot_e             slot_i,
    input  logic              word_valid_i,
    input  logic [WORD_W-1:0] word_data_i,
    output logic              word_ready_o,
    output logic              bit_o,
    output logic              underrun_o
);
    localparam int LW = $clog2(WORD_W + 1);

    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [LW-1:0]     left;
        logic              unf;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        word_ready_o = 1'b0;
        bit_o        = 1'b1;
        case (slot_i)
            SLOT_GAP: bit_o = 1'b0;
            SLOT_PAY: begin
                if (st_q.left == '0) begin
                    word_ready_o = 1'b1;
                    if (word_valid_i) begin
                        bit_o     = word_data_i[WORD_W-1];
                        st_d.sh   = word_data_i << 1;
                        st_d.left = LW'(WORD_W - 1);
                    end else begin
                        st_d.unf  = 1'b1;
                    end
                end else begin
                    bit_o     = st_q.sh[WORD_W-1];
                    st_d.sh   = st_q.sh << 1;
                    st_d.left = st_q.left - LW'(1);
                end
            end
            default: bit_o = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign underrun_o = st_q.unf;
endmodule

// File: rtl/ser_src_tx.sv
module ser_src_tx
    import ser_src_pkg::*;
#(
    parameter int WORD_W   = 8,
    parameter int PAY_BITS = 4704
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_strobe_i,
    input  logic              oh_warn_i,
    input  logic              word_valid_i,
    input  logic [WORD_W-1:0] word_data_i,
    output logic              word_ready_o,
    output logic              ser_o,
    output logic              underrun_o
);
    slot_e slot;
    logic  next_bit;
    logic  ser_d, ser_q;

    ser_src_slot_ctrl #(.PAY_BITS(PAY_BITS)) u_slot (
        .clk            (clk),
        .rst_n          (rst_n),
        .frame_strobe_i (frame_strobe_i),
        .oh_warn_i      (oh_warn_i),
        .slot_o         (slot)
    );

    ser_src_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .slot_i       (slot),
        .word_valid_i (word_valid_i),
        .word_data_i  (word_data_i),
        .word_ready_o (word_ready_o),
        .bit_o        (next_bit),
        .underrun_o   (underrun_o)
    );

    always_comb ser_d = next_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ser_q <= 1'b1;
        else        ser_q <= ser_d;
    end

    assign ser_o = ser_q;
endmodule

// File: rtl/ser_src_tx_chk.sv
module ser_src_tx_chk #(
    parameter int WORD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_strobe_i,
    input logic              oh_warn_i,
    input logic              word_valid_i,
    input logic [WORD_W-1:0] word_data_i,
    input logic              word_ready_o,
    input logic              ser_o,
    input logic              underrun_o
);
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              seen_q <= 1'b0;
        else if (frame_strobe_i) seen_q <= 1'b1;
    end

    p_gap_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        oh_warn_i |=> (ser_o == 1'b0));

    p_gap_no_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        oh_warn_i |-> !word_ready_o);

    p_no_pop_before_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_q && !frame_strobe_i) |-> !word_ready_o);

    p_fill_before_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_q && !frame_strobe_i && !oh_warn_i) |=> ser_o);

    p_underrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_o |=> underrun_o);

    p_underrun_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun_o) |-> $past(word_ready_o && !word_valid_i));

    p_underrun_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (word_ready_o && !word_valid_i) |=> ser_o);
endmodule

bind ser_src_tx ser_src_tx_chk #(.WORD_W(WORD_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .frame_strobe_i (frame_strobe_i),
    .oh_warn_i      (oh_warn_i),
    .word_valid_i   (word_valid_i),
    .word_data_i    (word_data_i),
    .word_ready_o   (word_ready_o),
    .ser_o          (ser_o),
    .underrun_o     (underrun_o)
);

// File: tb/ser_src_tx_test.sv
`timescale 1ns/1ps
module ser_src_tx_test;
    localparam int W   = 8;
    localparam int PAY = 4704;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         strobe = 1'b0;
    logic         oh = 1'b0;
    logic         valid = 1'b0;
    logic [W-1:0] data = '0;
    logic         ready, ser, unf;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // bench model state
    bit         m_inf;
    int         m_cnt;
    int         m_left;
    logic [W-1:0] m_sh;
    bit         m_unf;
    logic       exp_ser;
    string      exp_tag;
    int         widx;

    always #4 clk = ~clk;

    ser_src_tx #(.WORD_W(W), .PAY_BITS(PAY)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .frame_strobe_i (strobe),
        .oh_warn_i      (oh),
        .word_valid_i   (valid),
        .word_data_i    (data),
        .word_ready_o   (ready),
        .ser_o          (ser),
        .underrun_o     (unf)
    );

    function automatic logic [W-1:0] gen_word(input int k);
        int v;
        v = (k * 37 + 5) ^ (k >> 3);
        return v[W-1:0];
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_inf = 0; m_cnt = 0; m_left = 0; m_sh = '0; m_unf = 0;
        exp_ser = 1'b1; exp_tag = "R1";
    endtask

    // One bit clock: check last edge's result, drive new inputs, predict.
    task automatic step(input bit s, input bit o, input bit v);
        bit   pay;
        bit   exp_rdy;
        logic b;
        string t;
        @(negedge clk);
        chk(exp_tag, "ser_o", int'(ser), int'(exp_ser));
        chk("R7", "underrun_o", int'(unf), int'(m_unf));
        strobe = s; oh = o; valid = v; data = gen_word(widx);
        #1;
        pay     = !o && (s || (m_inf && m_cnt < PAY));
        exp_rdy = pay && (m_left == 0);
        chk("R6", "word_ready_o", int'(ready), int'(exp_rdy));
        if (pay) begin
            if (s && m_inf && m_cnt < PAY) t = "R9";
            else if (s)                    t = "R3";
            else                           t = "R4";
            if (m_left == 0) begin
                if (v) begin
                    b = data[W-1]; m_sh = data << 1; m_left = W - 1; widx++;
                end else begin
                    b = 1'b1; m_unf = 1; t = "R7";
                end
            end else begin
                b = m_sh[W-1]; m_sh = m_sh << 1; m_left--;
            end
            m_cnt = (s ? 0 : m_cnt) + 1;
        end else if (o) begin
            b = 1'b0;
            t = s ? "R10" : "R5";
            if (s) m_cnt = 0;
        end else begin
            b = 1'b1;
            t = (m_inf || s) ? "R8" : "R2";
        end
        if (s) m_inf = 1;
        exp_ser = b; exp_tag = t;
    endtask

    task automatic run_frame(input int len, input int pct, input bit oh_first);
        for (int i = 0; i < len; i++) begin
            bit o;
            o = (i == 0) ? oh_first : (($urandom % 100) == 0);
            step(i == 0, o, ($urandom % 100) < pct);
        end
    endtask

    task automatic reset_check();
        @(negedge clk);
        rst_n = 1'b0; strobe = 0; oh = 0; valid = 1;
        model_reset();
        repeat (2) @(negedge clk);
        chk("R1", "ser_o in reset", int'(ser), 1);
        chk("R1", "underrun_o in reset", int'(unf), 0);
        chk("R1", "word_ready_o in reset", int'(ready), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        widx = 0;
        model_reset();
        reset_check();
        // pre-frame fill, with a few overhead warnings (R2)
        for (int i = 0; i < 20; i++) step(0, (i % 7) == 3, 1);
        run_frame(4800, 100, 0);  // full frame, reaches idle fill (R8)
        run_frame(4800, 85, 0);   // upstream gaps, underrun (R7)
        run_frame(1000, 100, 0);  // cut short by early strobe (R9)
        run_frame(4800, 100, 1);  // strobe with overhead warning (R10)
        run_frame(300, 100, 0);
        step(0, 0, 1);
        reset_check();            // sticky flag cleared only by reset (R1, R7)
        for (int i = 0; i < 5; i++) step(0, 0, 1);
        step(1, 0, 1);
        for (int i = 0; i < 30; i++) step(0, 0, 1);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule